// File: doc/BRIEF.md
# Trace Sample Packer

The packer sits between a trace-port sampler and a 32-bit trace buffer. While capture is enabled it accepts one sample on every clock. Each sample carries a 3-bit pipeline status, a packet field, a sync flag and a trigger strobe. The packer gathers a fixed number of samples into one buffer word and emits the word with a one-cycle valid pulse. How many samples go into a word depends on the port width that was selected when capture began.

On the sample that carries the trigger, the status field of its slot holds a reserved trigger code. The real status is moved into the low three bits of that slot's packet field. The trigger is also raised on a side output together with the word that holds it.

When capture is switched off part-way through a word, the partly filled word is still written out. An empty flag shows when no partly filled word is held. A configuration that the packer cannot handle raises an error flag, and the packer then stays idle.

Top module: `trace_sample_packer`

## Requirements
- R1: After reset `w_valid` is 0, `empty` is 1 and `err` is 0.
- R2: With `width_sel`=0 (4-bit port), three samples make one word. The slots start at bits 0, 8 and 16, in arrival order. Within a slot, bits [2:0] hold the status, bits [6:3] hold packet[3:0] and bit 7 holds sync.
- R3: With `width_sel`=1 (8-bit port), two samples make one word. The first slot has status in [2:0], packet[7:0] in [10:3] and sync in [11]. The second slot has status in [14:12], packet in [22:15] and sync in [23].
- R4: With `width_sel`=2 (16-bit port), every sample makes one word. The status is in [2:0], packet[15:0] is in [18:3] and sync is in [19].
- R5: In the slot of a sample with `s_trig`=1, the status field holds TRIG_CODE (default 3'b110). The low three bits of that slot's packet field hold the sample's real status, and the upper packet bits are unchanged.
- R6: `w_trig` is 1 in exactly the cycle where `w_valid` presents a word that contains a trigger slot, and 0 with all other words.
- R7: Word bits above the last slot of the mode are 0: bits [31:24] in 4-bit and 8-bit modes, and bits [31:20] in 16-bit mode.
- R8: `port_sel`=1 (demultiplexed) is accepted only together with `width_sel`=1. Any other width then sets `err` and produces no words.
- R9: `port_sel`=2 (multiplexed), `port_sel`=3 and `width_sel`=3 are rejected. `err` goes to 1, the block stays idle and produces no words. `err` clears on the next accepted start.
- R10: When `cap_en` falls while a word is partly filled, that word is emitted with its unused slots zero in the cycle after the fall, and `empty` is 1 in that same cycle.
- R11: `empty` is 0 exactly while a partly filled word is held.
- R12: `width_sel` and `port_sel` are sampled only when capture starts. Changing them during capture does not alter the packing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_en | input | 1 | Capture enable; a rising level starts capture, a falling level stops it |
| width_sel | input | 2 | Port width: 0 = 4-bit, 1 = 8-bit, 2 = 16-bit, 3 = illegal |
| port_sel | input | 2 | Port mode: 0 = plain, 1 = demultiplexed, 2 = multiplexed, 3 = illegal |
| s_stat | input | 3 | Pipeline status of the sample |
| s_pkt | input | 16 | Packet field of the sample; only the low bits of the mode are used |
| s_sync | input | 1 | Sync flag of the sample |
| s_trig | input | 1 | Trigger strobe of the sample |
| w_valid | output | 1 | One-cycle pulse marking a packed word |
| w_data | output | 32 | Packed word |
| w_trig | output | 1 | The presented word holds a trigger slot |
| empty | output | 1 | No partly filled word is held |
| err | output | 1 | The last start request had an illegal configuration |

## Verification
The bench builds the packer with its default parameters: a trigger code of 3'b110 and a 32-bit word. This lets it use status values other than 6 as plain data. It can also check every slot boundary of all three widths against a fixed 32-bit layout. Trigger samples are placed in the first, middle and last slots. Flushes are made after one and after two samples. The bench also changes the configuration during a capture to show that the settings taken at start are kept.

// File: rtl/trace_sample_packer.sv
module trace_sample_packer #(
  parameter logic [2:0] TRIG_CODE = 3'b110,
  parameter int         WORD_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [1:0]        width_sel,
  input  logic [1:0]        port_sel,
  input  logic [2:0]        s_stat,
  input  logic [15:0]       s_pkt,
  input  logic              s_sync,
  input  logic              s_trig,
  output logic              w_valid,
  output logic [WORD_W-1:0] w_data,
  output logic              w_trig,
  output logic              empty,
  output logic              err
);
  localparam int SLOT_W = 20;

  logic              running;
  logic [1:0]        wmode;
  logic [1:0]        cnt;
  logic [1:0]        last_slot;
  logic [WORD_W-1:0] acc;
  logic              acc_trig;
  logic [2:0]        st_f;
  logic [15:0]       pkt_f;
  logic [SLOT_W-1:0] slot;
  logic [4:0]        shift;
  logic [WORD_W-1:0] placed;
  logic              cfg_ok;

  assign cfg_ok = (width_sel != 2'd3) &&
                  ((port_sel == 2'd0) || (port_sel == 2'd1 && width_sel == 2'd1));

  assign last_slot = (wmode == 2'd0) ? 2'd2 : (wmode == 2'd1) ? 2'd1 : 2'd0;

  assign st_f  = s_trig ? TRIG_CODE : s_stat;
  assign pkt_f = s_trig ? {s_pkt[15:3], s_stat} : s_pkt;

  always_comb begin
    case (wmode)
      2'd0:    slot = {12'b0, s_sync, pkt_f[3:0], st_f};
      2'd1:    slot = {8'b0, s_sync, pkt_f[7:0], st_f};
      default: slot = {s_sync, pkt_f, st_f};
    endcase
    case (wmode)
      2'd0:    shift = {cnt, 3'b000};
      2'd1:    shift = (cnt == 2'd1) ? 5'd12 : 5'd0;
      default: shift = 5'd0;
    endcase
  end

  assign placed = WORD_W'(slot) << shift;
  assign empty  = (cnt == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      wmode    <= 2'd0;
      cnt      <= 2'd0;
      acc      <= '0;
      acc_trig <= 1'b0;
      w_valid  <= 1'b0;
      w_data   <= '0;
      w_trig   <= 1'b0;
      err      <= 1'b0;
    end else begin
      w_valid <= 1'b0;
      w_trig  <= 1'b0;
      if (!running) begin
        if (cap_en) begin
          if (cfg_ok) begin
            running  <= 1'b1;
            err      <= 1'b0;
            wmode    <= width_sel;
            cnt      <= 2'd0;
            acc      <= '0;
            acc_trig <= 1'b0;
          end else begin
            err <= 1'b1;
          end
        end
      end else if (cap_en) begin
        if (cnt == last_slot) begin
          w_valid  <= 1'b1;
          w_data   <= acc | placed;
          w_trig   <= acc_trig | s_trig;
          cnt      <= 2'd0;
          acc      <= '0;
          acc_trig <= 1'b0;
        end else begin
          acc      <= acc | placed;
          acc_trig <= acc_trig | s_trig;
          cnt      <= cnt + 2'd1;
        end
      end else begin
        running <= 1'b0;
        if (cnt != 2'd0) begin
          w_valid <= 1'b1;
          w_data  <= acc;
          w_trig  <= acc_trig;
        end
        cnt      <= 2'd0;
        acc      <= '0;
        acc_trig <= 1'b0;
      end
    end
  end

  // R9
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !running);

  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid |-> (w_data[WORD_W-1:24] == '0) && (wmode != 2'd2 || w_data[23:20] == 4'd0));

  // R11
  empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> running);

  // R6
  trig_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && w_trig) |-> (w_data[2:0] == TRIG_CODE ||
      (wmode == 2'd0 && (w_data[10:8] == TRIG_CODE || w_data[18:16] == TRIG_CODE)) ||
      (wmode == 2'd1 && w_data[14:12] == TRIG_CODE)));

  // R10
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid |-> $past(running));
endmodule

// File: tb/trace_sample_packer_tb.sv
module trace_sample_packer_tb;
  localparam logic [2:0] TRIG = 3'b110;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_en = 1'b0;
  logic [1:0]  width_sel = 2'd0;
  logic [1:0]  port_sel = 2'd0;
  logic [2:0]  s_stat = 3'd0;
  logic [15:0] s_pkt = 16'd0;
  logic        s_sync = 1'b0;
  logic        s_trig = 1'b0;
  logic        w_valid;
  logic [31:0] w_data;
  logic        w_trig;
  logic        empty;
  logic        err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trace_sample_packer u_dut (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .width_sel(width_sel),
    .port_sel(port_sel), .s_stat(s_stat), .s_pkt(s_pkt), .s_sync(s_sync),
    .s_trig(s_trig), .w_valid(w_valid), .w_data(w_data), .w_trig(w_trig),
    .empty(empty), .err(err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] slotv(input int w, input logic [2:0] st,
                                        input logic [15:0] pk, input logic sy, input logic tr);
    logic [2:0]  so;
    logic [15:0] po;
    so = tr ? TRIG : st;
    po = tr ? {pk[15:3], st} : pk;
    if (w == 0)      slotv = {24'd0, sy, po[3:0], so};
    else if (w == 1) slotv = {20'd0, sy, po[7:0], so};
    else             slotv = {12'd0, sy, po, so};
  endfunction

  task automatic start(input logic [1:0] w, input logic [1:0] p);
    width_sel = w; port_sel = p; cap_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [2:0] st, input logic [15:0] pk, input logic sy, input logic tr);
    s_stat = st; s_pkt = pk; s_sync = sy; s_trig = tr;
    @(negedge clk);
    s_trig = 1'b0;
  endtask

  task automatic stop();
    cap_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 valid", {31'd0, w_valid}, 32'd0);
    check("R1 empty", {31'd0, empty}, 32'd1);
    check("R1 err", {31'd0, err}, 32'd0);
  endtask

  task automatic t_four();
    logic [31:0] e;
    start(2'd0, 2'd0);
    send(3'd5, 16'h000A, 1'b1, 1'b0);
    check("R11 empty low", {31'd0, empty}, 32'd0);
    send(3'd2, 16'h0003, 1'b0, 1'b0);
    check("R2 no early word", {31'd0, w_valid}, 32'd0);
    send(3'd7, 16'hFFF9, 1'b1, 1'b0);
    e = slotv(0, 3'd5, 16'h000A, 1'b1, 1'b0) | (slotv(0, 3'd2, 16'h0003, 1'b0, 1'b0) << 8)
      | (slotv(0, 3'd7, 16'hFFF9, 1'b1, 1'b0) << 16);
    check("R2 valid", {31'd0, w_valid}, 32'd1);
    check("R2 R7 word", w_data, e);
    check("R6 no trig", {31'd0, w_trig}, 32'd0);
    check("R11 empty high", {31'd0, empty}, 32'd1);
    send(3'd1, 16'h0004, 1'b0, 1'b0);
    send(3'd3, 16'h000D, 1'b0, 1'b1);
    send(3'd0, 16'h0001, 1'b0, 1'b0);
    e = slotv(0, 3'd1, 16'h0004, 1'b0, 1'b0) | (slotv(0, 3'd3, 16'h000D, 1'b0, 1'b1) << 8)
      | (slotv(0, 3'd0, 16'h0001, 1'b0, 1'b0) << 16);
    check("R5 trig middle slot", w_data, e);
    check("R6 trig word", {31'd0, w_trig}, 32'd1);
    stop();
    check("R10 no flush when empty", {31'd0, w_valid}, 32'd0);
  endtask

  task automatic t_eight();
    logic [31:0] e;
    start(2'd1, 2'd0);
    send(3'd4, 16'h12A5, 1'b0, 1'b1);
    send(3'd6, 16'h00FF, 1'b1, 1'b0);
    e = slotv(1, 3'd4, 16'h12A5, 1'b0, 1'b1) | (slotv(1, 3'd6, 16'h00FF, 1'b1, 1'b0) << 12);
    check("R3 valid", {31'd0, w_valid}, 32'd1);
    check("R3 R5 word", w_data, e);
    check("R6 trig first slot", {31'd0, w_trig}, 32'd1);
    stop();
  endtask

  task automatic t_sixteen();
    start(2'd2, 2'd0);
    send(3'd1, 16'hBEEF, 1'b1, 1'b0);
    check("R4 word", w_data, slotv(2, 3'd1, 16'hBEEF, 1'b1, 1'b0));
    check("R6 plain word", {31'd0, w_trig}, 32'd0);
    send(3'd2, 16'h8001, 1'b0, 1'b1);
    check("R5 R4 trig word", w_data, slotv(2, 3'd2, 16'h8001, 1'b0, 1'b1));
    check("R6 trig word 16", {31'd0, w_trig}, 32'd1);
    send(3'd0, 16'h0000, 1'b0, 1'b0);
    check("R6 trig cleared", {31'd0, w_trig}, 32'd0);
    stop();
  endtask

  task automatic t_demux();
    start(2'd1, 2'd1);
    check("R8 demux 8 ok", {31'd0, err}, 32'd0);
    send(3'd3, 16'h0011, 1'b0, 1'b0);
    send(3'd5, 16'h0022, 1'b0, 1'b0);
    check("R8 demux word", {31'd0, w_valid}, 32'd1);
    stop();
    start(2'd0, 2'd1);
    check("R8 demux 4 err", {31'd0, err}, 32'd1);
    for (int i = 0; i < 3; i++) begin
      send(3'd1, 16'h0005, 1'b0, 1'b0);
      check("R8 no word", {31'd0, w_valid}, 32'd0);
    end
    stop();
  endtask

  task automatic t_mux();
    start(2'd1, 2'd2);
    check("R9 mux err", {31'd0, err}, 32'd1);
    for (int i = 0; i < 3; i++) begin
      send(3'd2, 16'h0033, 1'b1, 1'b0);
      check("R9 idle", {31'd0, w_valid | ~empty}, 32'd0);
    end
    stop();
    start(2'd2, 2'd0);
    check("R9 err cleared", {31'd0, err}, 32'd0);
    stop();
  endtask

  task automatic t_flush();
    logic [31:0] e;
    start(2'd0, 2'd0);
    send(3'd6, 16'h0009, 1'b1, 1'b0);
    send(3'd2, 16'h0007, 1'b0, 1'b1);
    stop();
    e = slotv(0, 3'd6, 16'h0009, 1'b1, 1'b0) | (slotv(0, 3'd2, 16'h0007, 1'b0, 1'b1) << 8);
    check("R10 flush valid", {31'd0, w_valid}, 32'd1);
    check("R10 flush word", w_data, e);
    check("R10 flush trig", {31'd0, w_trig}, 32'd1);
    check("R10 empty", {31'd0, empty}, 32'd1);
    @(negedge clk);
    check("R10 single pulse", {31'd0, w_valid}, 32'd0);
    start(2'd1, 2'd0);
    send(3'd4, 16'h00C3, 1'b0, 1'b0);
    stop();
    check("R10 flush 8", w_data, slotv(1, 3'd4, 16'h00C3, 1'b0, 1'b0));
  endtask

  task automatic t_cfg_latch();
    logic [31:0] e;
    start(2'd0, 2'd0);
    width_sel = 2'd2; port_sel = 2'd2;
    send(3'd1, 16'h0002, 1'b0, 1'b0);
    check("R12 no word yet", {31'd0, w_valid}, 32'd0);
    send(3'd2, 16'h0003, 1'b0, 1'b0);
    send(3'd3, 16'h0004, 1'b1, 1'b0);
    e = slotv(0, 3'd1, 16'h0002, 1'b0, 1'b0) | (slotv(0, 3'd2, 16'h0003, 1'b0, 1'b0) << 8)
      | (slotv(0, 3'd3, 16'h0004, 1'b1, 1'b0) << 16);
    check("R12 packing kept", w_data, e);
    check("R12 err stays low", {31'd0, err}, 32'd0);
    stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_four();
    t_eight();
    t_sixteen();
    t_demux();
    t_mux();
    t_flush();
    t_cfg_latch();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule